// File: doc/BRIEF.md
# Packet Transmit Port Sequencer

This block runs the transmit side of a serial packet baseband toward a MAC. When the (polarity-adjusted) transmit enable rises, it produces a frame on its own. The frame starts with a run of sync ones and a start-of-frame word. Next comes a header made from the configured signal, service and length values, closed by an inverted CRC-16. Near the end of the header it starts a payload bit clock toward the MAC. It takes one payload bit per clock pulse and emits each one in the bit slot that follows. The enable going low ends the payload. The block then sends a short run of flush bits and returns to idle.

Output bits leave on `ser_bit`, qualified by a one-cycle `ser_valid` strobe, one bit every `BIT_CLKS` cycles. The modulation path behind the block runs at a fixed rate, so the stream has no back-pressure: the consumer must take every strobed bit. The ready flag tells the MAC that the header is done and payload is being taken. A new frame starts only after the enable has stayed low for a minimum time. Three configuration bits set the active level of the enable, the ready flag and the payload clock. A value of 1 makes that signal active low.

Top module: `tx_port_seq`

## Requirements
- R1: After reset the block is idle: no `ser_valid` pulse, and both ready and payload clock are at their inactive level.
- R2: An enable rising edge in idle starts a frame that begins with `SYNC_BITS` (128) one bits and then the word 0xF3A0, least significant bit first.
- R3: After the start word the header sends signal (8 bits), service (8 bits) and length (16 bits) in that order, each least significant bit first. These values are latched at frame start.
- R4: The CRC-16 is computed over the 32 header bits in the order they are sent. It is preset to 0xFFFF and uses polynomial 0x1021 (x^16+x^12+x^5+1): each bit is XORed with CRC bit 15, the CRC shifts left, and 0x1021 is XORed in when that result is 1. The inverted CRC is then sent, bit 0 first.
- R5: The payload clock gives one pulse per bit slot, starting in the slot of the last header bit, and only while the enable is active. The payload input is captured at each rising edge and emitted, in order, in the following slot.
- R6: Ready goes active in the same cycle as the strobe of the last header bit. It is never active before that bit.
- R7: The first slot with no captured payload bit starts the flush. `FLUSH_BITS` (2) zero bits are sent, ready goes inactive at the end of the last flush slot, and nothing further is strobed.
- R8: An enable rising edge starts a frame only in idle, and only if the enable was low for at least `MIN_LOW_CLKS` cycles just before. Any other rising edge is ignored.
- R9: An enable falling edge before the header is finished ends the frame early. The payload clock and ready stay inactive, `FLUSH_BITS` zero bits follow, and the block returns to idle.
- R10: The configuration bits invert the enable input, the ready output and the payload clock output independently (1 = active low).
- R11: While a frame runs, `ser_valid` pulses for exactly one cycle every `BIT_CLKS` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en_pol | input | 1 | Enable input polarity, 1 = active low |
| cfg_rdy_pol | input | 1 | Ready output polarity, 1 = active low |
| cfg_dclk_pol | input | 1 | Payload clock polarity, 1 = active low |
| cfg_signal | input | 8 | Signal field value |
| cfg_service | input | 8 | Service field value |
| cfg_length | input | 16 | Length field value |
| tx_en_pin | input | 1 | Transmit enable from the MAC |
| pay_bit | input | 1 | Serial payload bit from the MAC |
| dclk_pin | output | 1 | Payload bit clock to the MAC |
| rdy_pin | output | 1 | Ready flag to the MAC |
| ser_bit | output | 1 | Serial output bit |
| ser_valid | output | 1 | One-cycle strobe qualifying `ser_bit` |

## Verification
The bench checks several points. It checks the slot where the header hands over to payload: a design that starts the payload clock one slot late would drop a bit or shift ready off the last header bit. It checks a frame with a single payload bit and the exact count of flush zeros, which expose off-by-one errors in the flush counter. It raises the enable during flush, after too short a low period, and after enough low time. A guard that was too loose would start a frame it should ignore. It also cuts a frame during the preamble, where a wrong design would still raise ready or pulse the payload clock. It runs a frame with all three polarities inverted, where a missed inversion shows up as a frame that never starts or a handshake that stays stuck.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_SFD,
    ST_HDR,
    ST_DATA,
    ST_FLUSH
  } seq_state_t;

  localparam logic [15:0] CRC_POLY   = 16'h1021;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam int          HDR_FIELD_BITS = 32;
  localparam int          CRC_BITS       = 16;

  // Serial CRC over header bits, bit 0 of the vector processed first.
  function automatic logic [15:0] hdr_crc16(input logic [HDR_FIELD_BITS-1:0] d);
    logic [15:0] c;
    logic        fb;
    c = CRC_PRESET;
    for (int i = 0; i < HDR_FIELD_BITS; i++) begin
      fb = d[i] ^ c[15];
      c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return c;
  endfunction

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int BIT_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick,
  output logic cap_pt
);
  localparam int PW   = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam int HALF = BIT_CLKS / 2;

  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      ph <= '0;
    end else if (ph == PW'(BIT_CLKS - 1)) begin
      ph <= '0;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  // End of a bit slot: the next bit is launched here.
  assign tick   = run && (ph == PW'(BIT_CLKS - 1));
  // Mid-slot: payload clock rises and the payload input is sampled.
  assign cap_pt = run && (ph == PW'(HALF - 1));

endmodule

// File: rtl/tx_en_guard.sv
module tx_en_guard #(
  parameter int MIN_LOW_CLKS = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en_pin,
  input  logic cfg_en_pol,
  output logic en_act,
  output logic en_rise,
  output logic en_fall,
  output logic low_ok
);
  localparam int LW = $clog2(MIN_LOW_CLKS + 1);

  logic          en_q;
  logic [LW-1:0] low_cnt;

  assign en_act = tx_en_pin ^ cfg_en_pol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      low_cnt <= LW'(MIN_LOW_CLKS);
    end else begin
      en_q <= en_act;
      if (en_act) begin
        low_cnt <= '0;
      end else if (low_cnt != LW'(MIN_LOW_CLKS)) begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  assign en_rise = en_act && !en_q;
  assign en_fall = !en_act && en_q;
  assign low_ok  = (low_cnt == LW'(MIN_LOW_CLKS));

endmodule

// File: rtl/tx_hdr_crc.sv
module tx_hdr_crc
  import tx_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [7:0]  cfg_signal,
  input  logic [7:0]  cfg_service,
  input  logic [15:0] cfg_length,
  output logic [HDR_FIELD_BITS+CRC_BITS-1:0] hdr_bits
);
  logic [HDR_FIELD_BITS-1:0] fields_q;
  logic [CRC_BITS-1:0]       crc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fields_q <= '0;
    end else if (load) begin
      fields_q <= {cfg_length, cfg_service, cfg_signal};
    end
  end

  assign crc      = hdr_crc16(fields_q);
  assign hdr_bits = {~crc, fields_q};

endmodule

// File: rtl/tx_port_seq.sv
module tx_port_seq
  import tx_seq_pkg::*;
#(
  parameter int          BIT_CLKS     = 8,
  parameter int          SYNC_BITS    = 128,
  parameter logic [15:0] SFD_WORD     = 16'hF3A0,
  parameter int          FLUSH_BITS   = 2,
  parameter int          MIN_LOW_CLKS = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_en_pol,
  input  logic        cfg_rdy_pol,
  input  logic        cfg_dclk_pol,
  input  logic [7:0]  cfg_signal,
  input  logic [7:0]  cfg_service,
  input  logic [15:0] cfg_length,
  input  logic        tx_en_pin,
  input  logic        pay_bit,
  output logic        dclk_pin,
  output logic        rdy_pin,
  output logic        ser_bit,
  output logic        ser_valid
);
  localparam int HDR_BITS = HDR_FIELD_BITS + CRC_BITS;
  localparam int HW       = $clog2(HDR_BITS);
  localparam int CW       = $clog2(SYNC_BITS + HDR_BITS + FLUSH_BITS + 1);

  seq_state_t          state;
  logic [CW-1:0]       cnt;
  logic                rdy, dclk, cap_bit, cap_valid;
  logic                tick, cap_pt;
  logic                en_act, en_rise, en_fall, low_ok;
  logic                start, in_hdr_phase;
  logic [HDR_BITS-1:0] hdr_bits;

  tx_en_guard #(.MIN_LOW_CLKS(MIN_LOW_CLKS)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en_pin  (tx_en_pin),
    .cfg_en_pol (cfg_en_pol),
    .en_act     (en_act),
    .en_rise    (en_rise),
    .en_fall    (en_fall),
    .low_ok     (low_ok)
  );

  tx_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state != ST_IDLE),
    .tick   (tick),
    .cap_pt (cap_pt)
  );

  assign start = (state == ST_IDLE) && en_rise && low_ok;

  tx_hdr_crc u_hdr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (start),
    .cfg_signal  (cfg_signal),
    .cfg_service (cfg_service),
    .cfg_length  (cfg_length),
    .hdr_bits    (hdr_bits)
  );

  assign in_hdr_phase = (state == ST_SYNC) || (state == ST_SFD) || (state == ST_HDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      ser_bit   <= 1'b0;
      ser_valid <= 1'b0;
      rdy       <= 1'b0;
      dclk      <= 1'b0;
      cap_bit   <= 1'b0;
      cap_valid <= 1'b0;
    end else begin
      ser_valid <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          state     <= ST_SYNC;
          cnt       <= '0;
          cap_valid <= 1'b0;
        end
      end else if (en_fall && in_hdr_phase) begin
        // Early shutdown before payload: go straight to flush.
        state <= ST_FLUSH;
        cnt   <= '0;
      end else begin
        if (cap_pt && (state == ST_DATA) && en_act) begin
          cap_bit   <= pay_bit;
          cap_valid <= 1'b1;
          dclk      <= 1'b1;
        end
        if (tick) begin
          dclk <= 1'b0;
          unique case (state)
            ST_SYNC: begin
              ser_bit   <= 1'b1;
              ser_valid <= 1'b1;
              if (cnt == CW'(SYNC_BITS - 1)) begin
                state <= ST_SFD;
                cnt   <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            ST_SFD: begin
              ser_bit   <= SFD_WORD[cnt[3:0]];
              ser_valid <= 1'b1;
              if (cnt == CW'(15)) begin
                state <= ST_HDR;
                cnt   <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            ST_HDR: begin
              ser_bit   <= hdr_bits[cnt[HW-1:0]];
              ser_valid <= 1'b1;
              if (cnt == CW'(HDR_BITS - 1)) begin
                state <= ST_DATA;
                rdy   <= 1'b1;
                cnt   <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            ST_DATA: begin
              ser_valid <= 1'b1;
              if (cap_valid) begin
                ser_bit   <= cap_bit;
                cap_valid <= 1'b0;
              end else begin
                ser_bit <= 1'b0;
                state   <= ST_FLUSH;
                cnt     <= CW'(1);
              end
            end
            ST_FLUSH: begin
              if (cnt >= CW'(FLUSH_BITS)) begin
                state <= ST_IDLE;
                rdy   <= 1'b0;
                cnt   <= '0;
              end else begin
                ser_bit   <= 1'b0;
                ser_valid <= 1'b1;
                cnt       <= cnt + 1'b1;
              end
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign rdy_pin  = rdy ^ cfg_rdy_pol;
  assign dclk_pin = dclk ^ cfg_dclk_pol;

endmodule

// File: rtl/tx_port_seq_chk.sv
module tx_port_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_rdy_pol,
  input logic cfg_dclk_pol,
  input logic rdy_pin,
  input logic dclk_pin,
  input logic ser_valid
);
  logic rdy_act, dclk_act;
  assign rdy_act  = rdy_pin ^ cfg_rdy_pol;
  assign dclk_act = dclk_pin ^ cfg_dclk_pol;

  assert_strobe_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |=> !ser_valid);

  assert_dclk_in_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_act |-> rdy_act);

  assert_dclk_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_act) |=> dclk_act);

  assert_rdy_on_last_hdr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_act) |-> ser_valid);

  assert_rdy_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_act) |-> !ser_valid);

endmodule

bind tx_port_seq tx_port_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_rdy_pol  (cfg_rdy_pol),
  .cfg_dclk_pol (cfg_dclk_pol),
  .rdy_pin      (rdy_pin),
  .dclk_pin     (dclk_pin),
  .ser_valid    (ser_valid)
);

// File: tb/tx_port_seq_bench.sv
module tx_port_seq_bench;
  localparam int BIT    = 8;
  localparam int SYNC   = 128;
  localparam int FLUSH  = 2;
  localparam int MINLOW = 18;
  localparam int HDR_END = SYNC + 16 + 48 - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic pol_en, pol_rdy, pol_dclk;
  logic en_log;
  logic [7:0] sig, svc;
  logic [15:0] len;
  logic pay_bit;
  logic tx_en_pin;
  logic dclk_pin, rdy_pin, ser_bit, ser_valid;
  logic dclk_act, rdy_act;

  assign tx_en_pin = en_log ^ pol_en;
  assign dclk_act  = dclk_pin ^ pol_dclk;
  assign rdy_act   = rdy_pin ^ pol_rdy;

  always #2.5 clk = ~clk;

  tx_port_seq #(
    .BIT_CLKS(BIT), .SYNC_BITS(SYNC), .SFD_WORD(16'hF3A0),
    .FLUSH_BITS(FLUSH), .MIN_LOW_CLKS(MINLOW)
  ) u_tx_port_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_en_pol(pol_en), .cfg_rdy_pol(pol_rdy), .cfg_dclk_pol(pol_dclk),
    .cfg_signal(sig), .cfg_service(svc), .cfg_length(len),
    .tx_en_pin(tx_en_pin), .pay_bit(pay_bit),
    .dclk_pin(dclk_pin), .rdy_pin(rdy_pin),
    .ser_bit(ser_bit), .ser_valid(ser_valid)
  );

  int nchk = 0, nbad = 0;
  int cyc = 0;
  int bit_idx = 0;
  int last_v = -1;
  bit cap_mode = 0;
  logic sb_q[$];
  logic cap_bits[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [31:0] d);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < 32; i++) begin
      if (d[i] != c[15]) c = {c[14:0], 1'b0} ^ 16'h1021;
      else               c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

  // Monitor: pops the scoreboard on every strobe.
  always @(negedge clk) begin
    if (rst_n && ser_valid) begin
      if (cap_mode) begin
        cap_bits.push_back(ser_bit);
      end else begin
        string tag;
        logic  e;
        if (bit_idx < SYNC + 16)      tag = "R2";
        else if (bit_idx < SYNC + 48) tag = "R3";
        else if (bit_idx <= HDR_END)  tag = "R4";
        else                          tag = "R5";
        if (sb_q.size() == 0) begin
          check(0, "R7", "unexpected strobe at bit", bit_idx, -1);
        end else begin
          e = sb_q.pop_front();
          if (sb_q.size() < FLUSH && bit_idx > HDR_END) tag = "R7";
          check(ser_bit == e, tag, $sformatf("bit %0d value", bit_idx), ser_bit, e);
        end
        if (bit_idx == HDR_END)     check(rdy_act == 1'b1, "R6", "ready at last header bit", rdy_act, 1);
        if (bit_idx == HDR_END - 1) check(rdy_act == 1'b0, "R6", "ready before last header bit", rdy_act, 0);
        if (last_v >= 0)            check(cyc - last_v == BIT, "R11", "strobe spacing", cyc - last_v, BIT);
        last_v = cyc;
        bit_idx++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nbad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  task automatic push_frame(input logic [7:0] s, input logic [7:0] v, input logic [15:0] l,
                            input logic [63:0] pay, input int n);
    logic [31:0] f;
    logic [15:0] c;
    f = {l, v, s};
    c = ~ref_crc(f);
    for (int i = 0; i < SYNC; i++) sb_q.push_back(1'b1);
    for (int i = 0; i < 16; i++)   sb_q.push_back(16'hF3A0 >> i);
    for (int i = 0; i < 32; i++)   sb_q.push_back(f[i]);
    for (int i = 0; i < 16; i++)   sb_q.push_back(c[i]);
    for (int i = 0; i < n; i++)    sb_q.push_back(pay[i]);
    for (int i = 0; i < FLUSH; i++) sb_q.push_back(1'b0);
  endtask

  task automatic run_frame(input logic [7:0] s, input logic [7:0] v, input logic [15:0] l,
                           input logic [63:0] pay, input int n, input bit reraise);
    int  k, extra;
    bit  prev;
    sig = s; svc = v; len = l;
    bit_idx = 0; last_v = -1;
    push_frame(s, v, l, pay, n);
    pay_bit = pay[0];
    @(negedge clk) en_log = 1'b1;
    k = 0; prev = dclk_act;
    while (k < n) begin
      @(negedge clk);
      if (dclk_act && !prev) check(rdy_act == 1'b1, "R5", "ready during payload clock", rdy_act, 1);
      if (!dclk_act && prev) begin
        k++;
        if (k == n) en_log = 1'b0;
        else        pay_bit = pay[k];
      end
      prev = dclk_act;
    end
    if (reraise) begin
      while (sb_q.size() > 1) @(negedge clk);
      en_log = 1'b1;  // R8: rising edge during flush must be ignored
    end
    extra = 0; prev = dclk_act;
    while (rdy_act) begin
      @(negedge clk);
      if (dclk_act && !prev) extra++;
      prev = dclk_act;
    end
    check(extra == 0, "R5", "payload clock pulses after enable low", extra, 0);
    repeat (2 * BIT) @(negedge clk);
    check(sb_q.size() == 0, "R7", "bits left unsent", sb_q.size(), 0);
  endtask

  task automatic watch(input int n, output int nv, output int nr, output int nd);
    nv = 0; nr = 0; nd = 0;
    repeat (n) begin
      @(negedge clk);
      if (ser_valid) nv++;
      if (rdy_act)   nr++;
      if (dclk_act)  nd++;
    end
  endtask

  initial begin
    int nv, nr, nd, ones, zeros;
    bit order_ok;
    rst_n = 1'b0; pol_en = 0; pol_rdy = 0; pol_dclk = 0;
    en_log = 0; sig = 0; svc = 0; len = 0; pay_bit = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ser_valid == 1'b0, "R1", "strobe after reset", ser_valid, 0);
    check(rdy_pin == 1'b0, "R1", "ready after reset", rdy_pin, 0);
    check(dclk_pin == 1'b0, "R1", "payload clock after reset", dclk_pin, 0);
    watch(4 * BIT, nv, nr, nd);
    check(nv == 0, "R1", "strobes while idle", nv, 0);

    run_frame(8'h0A, 8'h00, 16'h0070, 64'h0000_0000_0000_0B6D, 12, 0);
    repeat (MINLOW + 5) @(negedge clk);
    run_frame(8'h14, 8'h04, 16'hBEEF, 64'h1, 1, 1);

    // R8: enable stays high after ignored edge, then a too-short low period
    watch(20 * BIT, nv, nr, nd);
    check(nv == 0, "R8", "strobes after edge during flush", nv, 0);
    en_log = 1'b0;
    repeat (5) @(negedge clk);
    en_log = 1'b1;
    watch(20 * BIT, nv, nr, nd);
    check(nv == 0, "R8", "strobes after short low period", nv, 0);
    check(nr == 0, "R8", "ready after short low period", nr, 0);
    en_log = 1'b0;
    repeat (MINLOW + 5) @(negedge clk);

    // R10: all polarities inverted
    pol_en = 1; pol_rdy = 1; pol_dclk = 1;
    @(negedge clk);
    check(rdy_pin == 1'b1, "R10", "inverted idle ready pin", rdy_pin, 1);
    check(dclk_pin == 1'b1, "R10", "inverted idle clock pin", dclk_pin, 1);
    run_frame(8'h6E, 8'h80, 16'h1234, 64'h0000_0000_000A_5F3C, 20, 0);
    repeat (MINLOW + 5) @(negedge clk);

    // R9: enable dropped during the preamble
    cap_mode = 1; cap_bits.delete();
    en_log = 1'b1;
    repeat (3 * BIT + 3) @(negedge clk);
    en_log = 1'b0;
    watch(12 * BIT, nv, nr, nd);
    check(nr == 0, "R9", "ready cycles in cut frame", nr, 0);
    check(nd == 0, "R9", "payload clock cycles in cut frame", nd, 0);
    ones = 0; zeros = 0; order_ok = 1;
    foreach (cap_bits[i]) begin
      if (cap_bits[i]) begin
        ones++;
        if (zeros != 0) order_ok = 0;
      end else begin
        zeros++;
      end
    end
    check(ones >= 1, "R9", "sync ones before cut", ones, 3);
    check(zeros == FLUSH, "R9", "flush zeros after cut", zeros, FLUSH);
    check(order_ok, "R9", "zeros only after ones", order_ok, 1);
    cap_mode = 0;

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule